// File: doc/BRIEF.md
# ADC Output Code Formatter

This block sits between a 10-bit sampling converter and the parallel output pins of an imaging front end. Each rising edge of the converter clock delivers one sample. The block re-codes that sample into one of four output formats: plain binary, Gray, a difference against the sample two clocks back, or that difference in Gray. It then applies optional bit inversions and registers the result onto the data bus. In the two difference formats, a receiver needs an occasional absolute sample to stay anchored. The block supplies a pair of them at a programmable distance after each rising edge of the optical-black pulse.

Pre-blanking overrides the data path. While the pre-blank input is asserted, at a polarity chosen by a configuration bit, the bus carries a fixed clamp code derived from a 5-bit clamp field. A standby bit withdraws the output enable so that the pads float. The reference pairs are placed by a small sequencer with three states. SEQ_IDLE waits for an optical-black rising edge, and the *arm* transition on that edge leads to SEQ_WAIT. SEQ_WAIT counts clock edges, and the *hit* transition on reaching the target edge leads to SEQ_SECOND. SEQ_SECOND emits the second reference sample, and the *release* transition returns to SEQ_IDLE.

Top module: `adc_out_fmt`

## Requirements
- R1: With code select 00 (binary), the value on `dout` after a rising clock edge equals the `adc_data` sample taken at that edge, so the latency is one clock.
- R2: With code select 01 (Gray), `dout` equals x XOR (x >> 1), where x is the sample taken at that edge.
- R3: With code select 10 (differential binary), `dout` equals (current sample − sample taken two edges earlier) modulo 1024, with the carry dropped.
- R4: With code select 11 (differential Gray), `dout` equals the Gray code, d XOR (d >> 1), of the R3 difference d.
- R5: Call the first edge at which `ob_pulse` is sampled high after having been sampled low edge 1. The samples taken at edges k and k+1, where k = 3 + `ref_pos`, are then output as absolute values. The codes are binary in mode 10 and Gray in mode 11. Modes 00 and 01 are unaffected.
- R6: `inv_msb` flips bit 9 and `inv_low` flips bits 8..0 of the encoded value. With both set, all ten bits are flipped. The inversions are applied after encoding.
- R7: While pre-blank is active, `dout` is 2·`clamp_sel` + 14 at the next edge, whatever the code select and inversion bits are.
- R8: Pre-blank is active when `pre_blank` is 1 with `pblk_low_act` = 0, and when `pre_blank` is 0 with `pblk_low_act` = 1.
- R9: `dout_oe` is 0 after any edge that samples `standby` high, and 1 after any edge that samples it low. The data path keeps running in standby. During reset, `dout` = 0 and `dout_oe` = 0.
- R10: An `ob_pulse` rising edge that arrives while a reference pair is still pending (SEQ_WAIT or SEQ_SECOND) is ignored, so no extra pair is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_data | input | 10 | Converter sample |
| ob_pulse | input | 1 | Optical-black pulse, active high |
| pre_blank | input | 1 | Pre-blank request, polarity set by `pblk_low_act` |
| code_sel | input | 2 | Output code: 00 binary, 01 Gray, 10 differential binary, 11 differential Gray |
| ref_pos | input | 2 | Position of the reference pair after the optical-black edge |
| inv_msb | input | 1 | Invert bit 9 |
| inv_low | input | 1 | Invert bits 8..0 |
| clamp_sel | input | 5 | Clamp field; clamp code = 2·field + 14 |
| pblk_low_act | input | 1 | 1 makes pre-blank active low |
| standby | input | 1 | Withdraw output enable |
| dout | output | 10 | Registered output code |
| dout_oe | output | 1 | Output enable for the pad drivers |

## Verification
A history register that holds a stale or wrong sample corrupts every difference code on the very next edge. After that, the error persists for exactly two edges per bad entry. A sequencer stuck in the wrong state, or counting from the wrong edge, shows up as absolute codes appearing one or more clocks away from edge 3 + `ref_pos` of the pulse. It can also show up as a missing or third reference sample. This is visible within seven clocks of an optical-black edge. A wrong blanking polarity or clamp arithmetic shows on the first edge after pre-blank changes.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic [1:0] {
        ENC_BIN   = 2'b00,
        ENC_GRAY  = 2'b01,
        ENC_DBIN  = 2'b10,
        ENC_DGRAY = 2'b11
    } enc_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'b00,
        SEQ_WAIT   = 2'b01,
        SEQ_SECOND = 2'b10
    } seq_state_e;

endpackage

// File: rtl/ref_seq.sv
module ref_seq
    import adc_fmt_pkg::*;
#(
    parameter int POS_W  = 2,
    parameter int BASE   = 3,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ob_in,
    input  logic [POS_W-1:0] pos,
    output logic             is_ref
);

    seq_state_e       state, state_nxt;
    logic [CNT_W-1:0] edge_no, edge_nxt;
    logic             ob_q;
    logic             ob_rise;
    logic [CNT_W-1:0] target;

    assign ob_rise = ob_in && !ob_q;
    assign target  = CNT_W'(BASE) + CNT_W'(pos);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            edge_no <= '0;
            ob_q    <= 1'b0;
        end else begin
            state   <= state_nxt;
            edge_no <= edge_nxt;
            ob_q    <= ob_in;
        end
    end

    // transitions: arm, hit, release
    always_comb begin
        state_nxt = state;
        edge_nxt  = edge_no;
        unique case (state)
            SEQ_IDLE: begin
                if (ob_rise) begin
                    state_nxt = SEQ_WAIT;
                    edge_nxt  = CNT_W'(2);
                end
            end
            SEQ_WAIT: begin
                edge_nxt = edge_no + CNT_W'(1);
                if (edge_no == target) begin
                    state_nxt = SEQ_SECOND;
                end
            end
            SEQ_SECOND: begin
                state_nxt = SEQ_IDLE;
            end
            default: begin
                state_nxt = SEQ_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            SEQ_WAIT:   is_ref = (edge_no == target);
            SEQ_SECOND: is_ref = 1'b1;
            default:    is_ref = 1'b0;
        endcase
    end

    // R5: the first reference sample is always followed by a second one
    p_pair_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAIT && is_ref) |=> is_ref);

    // R10: a pair never grows into a third reference sample
    p_no_third_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SECOND) |=> !is_ref);

    // R5: an optical-black edge seen in idle arms the count
    p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && ob_in && !ob_q) |=> (state == SEQ_WAIT && !is_ref || pos == '0 && 1'b0 || state == SEQ_WAIT));

endmodule

// File: rtl/sample_hist.sv
module sample_hist #(
    parameter int DW    = 10,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] oldest
);

    logic [DEPTH-1:0][DW-1:0] stage;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= '0;
                else        stage[0] <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage <= '0;
                end else begin
                    stage[0] <= din;
                    for (int i = 1; i < DEPTH; i++) begin
                        stage[i] <= stage[i-1];
                    end
                end
            end
        end
    endgenerate

    assign oldest = stage[DEPTH-1];

endmodule

// File: rtl/code_xform.sv
module code_xform
    import adc_fmt_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] old,
    input  logic          is_ref,
    input  enc_mode_e     mode,
    input  logic          inv_msb,
    input  logic          inv_low,
    output logic [DW-1:0] enc
);

    logic [DW-1:0] delta;
    logic [DW-1:0] base;
    logic [DW-1:0] coded;

    assign delta = cur - old;

    always_comb begin
        unique case (mode)
            ENC_BIN: begin
                base  = cur;
                coded = base;
            end
            ENC_GRAY: begin
                base  = cur;
                coded = base ^ (base >> 1);
            end
            ENC_DBIN: begin
                base  = is_ref ? cur : delta;
                coded = base;
            end
            ENC_DGRAY: begin
                base  = is_ref ? cur : delta;
                coded = base ^ (base >> 1);
            end
            default: begin
                base  = cur;
                coded = base;
            end
        endcase
    end

    assign enc = {coded[DW-1] ^ inv_msb, coded[DW-2:0] ^ {(DW-1){inv_low}}};

endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
    import adc_fmt_pkg::*;
#(
    parameter int DW         = 10,
    parameter int CLAMP_W    = 5,
    parameter int CLAMP_BASE = 14,
    parameter int POS_W      = 2,
    parameter int REF_BASE   = 3,
    parameter int HIST_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DW-1:0]      adc_data,
    input  logic               ob_pulse,
    input  logic               pre_blank,
    input  logic [1:0]         code_sel,
    input  logic [POS_W-1:0]   ref_pos,
    input  logic               inv_msb,
    input  logic               inv_low,
    input  logic [CLAMP_W-1:0] clamp_sel,
    input  logic               pblk_low_act,
    input  logic               standby,
    output logic [DW-1:0]      dout,
    output logic               dout_oe
);

    localparam int MAX_EDGE = REF_BASE + (2 ** POS_W);
    localparam int CNT_W    = $clog2(MAX_EDGE + 1);

    logic [DW-1:0] old_sample;
    logic [DW-1:0] enc;
    logic [DW-1:0] clamp_code;
    logic          is_ref;
    logic          blank_act;
    enc_mode_e     mode;

    assign mode       = enc_mode_e'(code_sel);
    assign blank_act  = pre_blank ^ pblk_low_act;
    assign clamp_code = DW'(CLAMP_BASE) + (DW'(clamp_sel) << 1);

    sample_hist #(.DW(DW), .DEPTH(HIST_DEPTH)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (adc_data),
        .oldest (old_sample)
    );

    ref_seq #(.POS_W(POS_W), .BASE(REF_BASE), .CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ob_in  (ob_pulse),
        .pos    (ref_pos),
        .is_ref (is_ref)
    );

    code_xform #(.DW(DW)) u_xform (
        .cur     (adc_data),
        .old     (old_sample),
        .is_ref  (is_ref),
        .mode    (mode),
        .inv_msb (inv_msb),
        .inv_low (inv_low),
        .enc     (enc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout_oe <= !standby;
            dout    <= blank_act ? clamp_code : enc;
        end
    end

    p_bin_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_sel == 2'b00 && !blank_act && !inv_msb && !inv_low)
        |=> dout == $past(adc_data));

    p_msb_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_sel == 2'b00 && !blank_act && inv_msb && !inv_low)
        |=> dout == ($past(adc_data) ^ (DW'(1) << (DW-1))));

    p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank_act |=> dout == DW'(CLAMP_BASE) + (DW'($past(clamp_sel)) << 1));

    p_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !dout_oe);

    p_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !standby |=> dout_oe);

endmodule

// File: tb/sim_adc_out_fmt.sv
`timescale 1ns/1ps
module sim_adc_out_fmt;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] adc;
    logic       obp, pblk;
    logic [1:0] mode, pos;
    logic       im, il, pinv, stby;
    logic [4:0] clamp;
    wire  [9:0] dout;
    wire        oe;

    int n_cmp = 0;
    int n_bad = 0;

    logic [9:0]  s1, s2;
    logic        prev_ob;
    int          since;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    adc_out_fmt u0 (
        .clk(clk), .rst_n(rst_n), .adc_data(adc), .ob_pulse(obp),
        .pre_blank(pblk), .code_sel(mode), .ref_pos(pos), .inv_msb(im),
        .inv_low(il), .clamp_sel(clamp), .pblk_low_act(pinv),
        .standby(stby), .dout(dout), .dout_oe(oe)
    );

    function automatic logic [9:0] rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[9:0];
    endfunction

    task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic step(input logic [9:0] d, input logic ob, input logic pb_pin, input string over);
        int k;
        logic rf, pa;
        logic [9:0] v;
        string tag;
        @(negedge clk);
        adc = d; obp = ob; pblk = pb_pin;
        @(posedge clk);
        #1;
        k = 3 + int'(pos);
        if (since > 0) begin
            since++;
            if (since > k + 1) since = 0;
        end
        if (since == 0 && ob && !prev_ob) since = 1;
        rf = (since == k) || (since == k + 1);
        pa = pb_pin ^ pinv;
        if (pa) begin
            v = 10'(2 * int'(clamp) + 14);
            tag = pinv ? "R8" : "R7";
        end else begin
            v = (mode[1] && !rf) ? 10'(d - s2) : d;
            if (mode[0]) v = v ^ (v >> 1);
            if (im) v = v ^ 10'h200;
            if (il) v = v ^ 10'h1FF;
            if (mode[1] && rf) tag = "R5";
            else case (mode)
                2'b00: tag = "R1";
                2'b01: tag = "R2";
                2'b10: tag = "R3";
                default: tag = "R4";
            endcase
            if (im || il) tag = {tag, "+R6"};
        end
        if (over != "") tag = over;
        chk(tag, dout, v);
        chk("R9 enable", {9'd0, oe}, {9'd0, !stby});
        s2 = s1; s1 = d; prev_ob = ob;
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; adc = '0; obp = 0; pblk = 0; mode = 0; pos = 0;
        im = 0; il = 0; pinv = 0; stby = 0; clamp = 0;
        s1 = 0; s2 = 0; prev_ob = 0; since = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset dout", dout, 10'd0);
        chk("R9 reset oe", {9'd0, oe}, 10'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1, R2: every code in binary then Gray
        for (int m = 0; m < 2; m++) begin
            mode = 2'(m);
            for (int v = 0; v < 1024; v++) step(10'(v), 0, 0, "");
        end

        // R3: wrap of the difference
        mode = 2'b10;
        step(10'd1023, 0, 0, "");
        step(10'd0, 0, 0, "");
        step(10'd1, 0, 0, "R3 wrap");

        // R1..R6: all modes, inversions and reference positions
        for (int m = 0; m < 4; m++) begin
            for (int iv = 0; iv < 4; iv++) begin
                mode = 2'(m); im = iv[1]; il = iv[0]; pos = 2'((m + iv) % 4);
                for (int i = 0; i < 48; i++) begin
                    step(rnd(), ((i % 16) >= 2) && ((i % 16) <= 4), 0, "");
                end
            end
        end

        // R7, R8: every clamp field, both polarities
        for (int p = 0; p < 2; p++) begin
            pinv = p[0];
            for (int c = 0; c < 32; c++) begin
                clamp = 5'(c); mode = 2'(c % 4); im = c[0]; il = c[1];
                step(rnd(), 0, p ? 1'b0 : 1'b1, "");
                step(rnd(), 0, p ? 1'b1 : 1'b0, "");
            end
        end
        pinv = 0; im = 0; il = 0;

        // R9: standby
        stby = 1;
        repeat (4) step(rnd(), 0, 0, "");
        stby = 0;
        repeat (2) step(rnd(), 0, 0, "");

        // R10: second rising edge inside a pending pair
        mode = 2'b10; pos = 2'd0;
        repeat (4) step(rnd(), 0, 0, "R10");
        step(10'd100, 1, 0, "R10");
        step(10'd200, 0, 0, "R10");
        step(10'd300, 1, 0, "R10");
        step(10'd400, 1, 0, "R10");
        step(10'd500, 1, 0, "R10");
        step(10'd600, 1, 0, "R10");
        step(10'd700, 1, 0, "R10");
        step(10'd800, 0, 0, "R10");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule